// File: doc/BRIEF.md
# Unified Add/Subtract Arithmetic Unit

This block is the integer adder of an execution pipeline. Every add and subtract form passes through one datapath: plain, carrying, extended, minus-one-extended and zero-extended, each as an add or a subtract. The datapath computes `(A, optionally inverted) + B + carry-in` in a single 65-bit sum. The low 64 bits form the result and the top bit is the carry-out.

The instruction decoder sets four controls:
- an invert-A control;
- a two-bit selector that picks B from the second register operand, constant zero or constant all-ones;
- a two-bit selector that picks the carry-in from zero, one or the stored carry flag;
- a flag that asks for the carry flag to be recorded.

A subtract "B minus A" is written as invert A, B from the register, carry-in one. The unit has no clock. The sum and carry-out settle in the same cycle as the inputs. A write-enable next to the carry-out tells the register file whether the carry flag is to take it.

Top module: `arithAddSub`

## Requirements
- R1: `sum` equals the low WIDTH bits of `(invertA ? ~opA : opA) + Bvalue + Cin`, where Bvalue and Cin come from the selectors described in R3 and R4.
- R2: `carryOut` equals bit WIDTH of that same (WIDTH+1)-bit unsigned sum.
- R3: Encoding of `bSel`: 0 selects `opB`, 1 selects constant zero, 2 selects constant all-ones, and the reserved code 3 behaves like code 1.
- R4: Encoding of `cSel`: 0 selects carry-in zero, 1 selects carry-in one, 2 selects `carryFlag`, and the reserved code 3 behaves like code 0.
- R5: When `cSel` is not 2, `carryFlag` has no effect on `sum` or `carryOut`.
- R6: With `invertA`=1, `bSel`=0 and `cSel`=1, `sum` equals `opB - opA` modulo 2^WIDTH, and `carryOut` is 1 exactly when `opB >= opA` (unsigned).
- R7: With `bSel`=2 and `cSel`=2, `sum` equals `opA + carryFlag - 1`. When `invertA` is also 1, `sum` equals `~opA + carryFlag - 1`.
- R8: `carryWe` equals `recordCarry` for every setting of the other inputs. The decoder raises `recordCarry` only for carrying and extended forms.
- R9: The unit is combinational. After any change of its inputs, the outputs take the new values with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First register operand |
| opB | input | 64 | Second register operand |
| invertA | input | 1 | Invert A before the add |
| bSel | input | 2 | B source selector |
| cSel | input | 2 | Carry-in source selector |
| carryFlag | input | 1 | Current stored carry flag |
| recordCarry | input | 1 | Operation updates the carry flag |
| sum | output | 64 | Result |
| carryOut | output | 1 | Carry out of the top bit |
| carryWe | output | 1 | Write-enable for the carry flag |

## Verification
The carry chain is hardest to reach from the ports: a carry that starts at bit 0 and must ripple through every chunk boundary to reach `carryOut`. Random 64-bit operands almost never produce a long run of ones, so the random stimulus rarely gets there. The stimulus therefore adds directed cases built for it:
- an all-ones A with carry-in one;
- a subtract of equal operands;
- a subtract of zero from zero;
- the minus-one forms with A zero and with A all-ones.

The random phase also forces A or B to all-ones or zero on a fraction of the iterations.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [1:0] {
    B_FROM_REG = 2'd0,
    B_ZERO     = 2'd1,
    B_ONES     = 2'd2,
    B_RSVD     = 2'd3
  } bSrc_e;

  typedef enum logic [1:0] {
    C_ZERO = 2'd0,
    C_ONE  = 2'd1,
    C_FLAG = 2'd2,
    C_RSVD = 2'd3
  } cSrc_e;

  // Strobes from the control decode into the datapath
  typedef struct packed {
    logic invA;
    logic bUseReg;
    logic bUseOnes;
    logic cinOne;
    logic cinFlag;
    logic carryWe;
  } addStrobes_t;

endpackage

// File: rtl/arithCtrl.sv
module arithCtrl
  import arith_pkg::*;
(
  input  logic        invertA,
  input  logic [1:0]  bSel,
  input  logic [1:0]  cSel,
  input  logic        recordCarry,
  output addStrobes_t strobes
);

  bSrc_e bSrc;
  cSrc_e cSrc;

  always_comb begin
    bSrc = bSrc_e'(bSel);
    cSrc = cSrc_e'(cSel);
    strobes = '0;
    strobes.invA    = invertA;
    strobes.carryWe = recordCarry;
    unique case (bSrc)
      B_FROM_REG: strobes.bUseReg  = 1'b1;
      B_ONES:     strobes.bUseOnes = 1'b1;
      default:    ;
    endcase
    unique case (cSrc)
      C_ONE:   strobes.cinOne  = 1'b1;
      C_FLAG:  strobes.cinFlag = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/arithChunkAdder.sv
module arithChunkAdder #(
  parameter int CHUNK = 16
) (
  input  logic [CHUNK-1:0] aIn,
  input  logic [CHUNK-1:0] bIn,
  input  logic             cIn,
  output logic [CHUNK-1:0] sOut,
  output logic             cOut
);

  logic [CHUNK:0] wide;

  always_comb begin
    wide = {1'b0, aIn} + {1'b0, bIn} + {{CHUNK{1'b0}}, cIn};
    sOut = wide[CHUNK-1:0];
    cOut = wide[CHUNK];
  end

endmodule

// File: rtl/arithDatapath.sv
module arithDatapath
  import arith_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CHUNK = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryFlag,
  input  addStrobes_t      strobes,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);

  localparam int NCHUNK = WIDTH / CHUNK;

  logic [WIDTH-1:0] aVal;
  logic [WIDTH-1:0] bVal;
  logic             cin;
  logic [NCHUNK:0]  chain;

  always_comb begin
    aVal = strobes.invA ? ~opA : opA;
    if (strobes.bUseReg)       bVal = opB;
    else if (strobes.bUseOnes) bVal = '1;
    else                       bVal = '0;
    cin = strobes.cinOne | (strobes.cinFlag & carryFlag);
  end

  assign chain[0] = cin;

  for (genvar g = 0; g < NCHUNK; g++) begin : gChunk
    arithChunkAdder #(.CHUNK(CHUNK)) i_chunk (
      .aIn  (aVal[g*CHUNK +: CHUNK]),
      .bIn  (bVal[g*CHUNK +: CHUNK]),
      .cIn  (chain[g]),
      .sOut (sum[g*CHUNK +: CHUNK]),
      .cOut (chain[g+1])
    );
  end

  assign carryOut = chain[NCHUNK];

endmodule

// File: rtl/arithAddSub.sv
module arithAddSub
  import arith_pkg::*;
#(
  parameter int WIDTH = 64,
  parameter int CHUNK = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             invertA,
  input  logic [1:0]       bSel,
  input  logic [1:0]       cSel,
  input  logic             carryFlag,
  input  logic             recordCarry,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut,
  output logic             carryWe
);

  addStrobes_t strobes;

  arithCtrl i_ctrl (
    .invertA     (invertA),
    .bSel        (bSel),
    .cSel        (cSel),
    .recordCarry (recordCarry),
    .strobes     (strobes)
  );

  arithDatapath #(.WIDTH(WIDTH), .CHUNK(CHUNK)) i_dp (
    .opA       (opA),
    .opB       (opB),
    .carryFlag (carryFlag),
    .strobes   (strobes),
    .sum       (sum),
    .carryOut  (carryOut)
  );

  assign carryWe = strobes.carryWe;

endmodule

// File: rtl/arithAddSub_checker.sv
module arithAddSub_checker #(
  parameter int WIDTH = 64
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             invertA,
  input logic [1:0]       bSel,
  input logic [1:0]       cSel,
  input logic             carryFlag,
  input logic             recordCarry,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut,
  input logic             carryWe
);

  logic known;
  assign known = !$isunknown({opA, opB, invertA, bSel, cSel, carryFlag, recordCarry});

  always_comb begin
    if (known) begin
      // R8: write-enable tracks the request only
      p_we_follows_r8: assert (carryWe == recordCarry);
      // R3 / R4: zero B and zero carry pass A straight through
      if (!invertA && (bSel == 2'd1 || bSel == 2'd3) && (cSel == 2'd0 || cSel == 2'd3))
        p_pass_a_r3: assert (sum == opA && carryOut == 1'b0);
      // R6: subtract form
      if (invertA && bSel == 2'd0 && cSel == 2'd1)
        p_subtract_r6: assert (sum == opB - opA && carryOut == (opB >= opA));
      // R7: minus-one extended add
      if (!invertA && bSel == 2'd2 && cSel == 2'd2)
        p_minus_one_r7: assert (sum == opA + {{(WIDTH-1){1'b0}}, carryFlag} - 1'b1);
      // R2: adding zero with carry one overflows only from all-ones
      if (!invertA && bSel == 2'd1 && cSel == 2'd1)
        p_carry_top_r2: assert (carryOut == (&opA));
    end
  end

endmodule

bind arithAddSub arithAddSub_checker #(.WIDTH(WIDTH)) i_checker (
  .opA         (opA),
  .opB         (opB),
  .invertA     (invertA),
  .bSel        (bSel),
  .cSel        (cSel),
  .carryFlag   (carryFlag),
  .recordCarry (recordCarry),
  .sum         (sum),
  .carryOut    (carryOut),
  .carryWe     (carryWe)
);

// File: tb/test_arithAddSub.sv
module test_arithAddSub;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic         invertA = 1'b0, carryFlag = 1'b0, recordCarry = 1'b0;
  logic [1:0]   bSel = 2'd1, cSel = 2'd0;
  logic [W-1:0] sum;
  logic         carryOut, carryWe;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  arithAddSub i_arithAddSub (
    .opA(opA), .opB(opB), .invertA(invertA), .bSel(bSel), .cSel(cSel),
    .carryFlag(carryFlag), .recordCarry(recordCarry),
    .sum(sum), .carryOut(carryOut), .carryWe(carryWe)
  );

  function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                       input logic inv, input logic [1:0] bs,
                                       input logic [1:0] cs, input logic cf);
    logic [W-1:0] aa, bb;
    logic c;
    aa = inv ? ~a : a;
    bb = (bs == 2'd0) ? b : (bs == 2'd2) ? {W{1'b1}} : {W{1'b0}};
    c  = (cs == 2'd1) ? 1'b1 : (cs == 2'd2) ? cf : 1'b0;
    return {1'b0, aa} + {1'b0, bb} + {{W{1'b0}}, c};
  endfunction

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic inv,
                       input logic [1:0] bs, input logic [1:0] cs, input logic cf,
                       input logic rc);
    @(negedge clk);
    opA = a; opB = b; invertA = inv; bSel = bs; cSel = cs; carryFlag = cf; recordCarry = rc;
    #1;
  endtask

  task automatic checkAll(input string tag);
    logic [W:0] e;
    e = model(opA, opB, invertA, bSel, cSel, carryFlag);
    check({tag, " R1 sum"}, {1'b0, sum}, {1'b0, e[W-1:0]});
    check({tag, " R2 carry"}, {{W{1'b0}}, carryOut}, {{W{1'b0}}, e[W]});
    check({tag, " R8 we"}, {{W{1'b0}}, carryWe}, {{W{1'b0}}, recordCarry});
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    logic [W-1:0] s0;
    logic c0;
    void'($urandom(32'd1234));
    #1;
    // initial state: A=0, B zero, C zero -> 0
    check("R1 initial", {carryOut, sum}, '0);

    // R6 subtract corners
    apply(64'd5, 64'd9, 1, 0, 1, 0, 0);
    check("R6 9-5", {carryOut, sum}, {1'b1, 64'd4});
    apply(64'd9, 64'd5, 1, 0, 1, 0, 0);
    check("R6 5-9", {carryOut, sum}, {1'b0, 64'd5 - 64'd9});
    apply(64'h1234, 64'h1234, 1, 0, 1, 0, 1);
    check("R6 equal", {carryOut, sum}, {1'b1, 64'd0});
    apply('0, '0, 1, 0, 1, 0, 1);
    check("R6 zero", {carryOut, sum}, {1'b1, 64'd0});

    // R2 long ripple: all-ones + 0 + 1
    apply('1, '0, 0, 1, 1, 0, 0);
    check("R2 ripple", {carryOut, sum}, {1'b1, 64'd0});

    // R7 minus-one extended
    apply('0, '0, 0, 2, 2, 0, 1);
    check("R7 0-1", {carryOut, sum}, {1'b0, {W{1'b1}}});
    apply('0, '0, 0, 2, 2, 1, 1);
    check("R7 0+cf-1", {carryOut, sum}, {1'b1, 64'd0});
    apply('1, '0, 1, 2, 2, 1, 1);
    check("R7 inv ones", {1'b0, sum}, {1'b0, 64'd0});
    apply(64'd100, '0, 0, 2, 2, 0, 1);
    check("R7 100-1", {1'b0, sum}, {1'b0, 64'd99});

    // R3 reserved B code = zero
    apply(64'hABCD, 64'hFFFF, 0, 3, 0, 0, 0);
    check("R3 rsvd b", {carryOut, sum}, {1'b0, 64'hABCD});
    apply(64'hABCD, 64'hFFFF, 0, 2, 0, 0, 0);
    check("R3 ones b", {1'b0, sum}, {1'b0, 64'hABCC});
    // R4 reserved carry code = zero even with flag set
    apply(64'h10, '0, 0, 1, 3, 1, 0);
    check("R4 rsvd c", {carryOut, sum}, {1'b0, 64'h10});
    apply(64'h10, '0, 0, 1, 2, 1, 0);
    check("R4 flag c", {carryOut, sum}, {1'b0, 64'h11});

    // R5 flag ignored unless selector is 2
    for (int k = 0; k < 8; k++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      apply(a, b, k[0], 2'(k % 3), (k[1] ? 2'd1 : 2'd0), 0, 0);
      s0 = sum; c0 = carryOut;
      apply(a, b, k[0], 2'(k % 3), (k[1] ? 2'd1 : 2'd0), 1, 0);
      check("R5 flag ignored", {carryOut, sum}, {c0, s0});
    end

    // R9 combinational: outputs follow without clock edge
    @(negedge clk);
    opA = 64'd7; opB = 64'd8; invertA = 0; bSel = 0; cSel = 0; recordCarry = 0;
    #0.5;
    check("R9 no edge", {carryOut, sum}, {1'b0, 64'd15});
    opA = 64'd1;
    #0.5;
    check("R9 retrack", {carryOut, sum}, {1'b0, 64'd9});

    // R1 R2 R8 random mix
    for (int i = 0; i < 3000; i++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if ($urandom % 8 == 0) a = '1;
      if ($urandom % 8 == 1) b = '1;
      if ($urandom % 8 == 2) a = '0;
      if ($urandom % 8 == 3) b = ~a;
      apply(a, b, 1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
      checkAll("rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule